// File: doc/BRIEF.md
# Addressed three-wire display command receiver

This block takes display and control frames from a host over three wires: an enable line, a serial clock and a data line. All three are brought into the system clock domain by two-flop synchronizers, and the block finds their edges there. Data is sampled on each rising edge of the serial clock. While enable is low, those samples form an 8-bit device address. While enable is high, they form a 40-bit payload.

When enable falls, the block checks the frame. A frame is committed only if the address matched and exactly 40 payload bits arrived. The last payload bit selects which half of a 64-bit display store the frame's 32 display bits are written to. A lower-half frame also carries six control bits. These set the number of segment pins handed over to general-purpose use, the bias mode, segment blanking and power-save. An upper-half frame leaves the control bits alone.

A display-inhibit input forces every pin back to its segment role and asserts the drive-off output. It does not stop frames from being received and stored. Each commit produces a one-cycle pulse that names the half that was written.

Top module: `disp_cmd_rx`

## Requirements
- R1: While reset is asserted, the display store is all zeros and the control fields are zero. gp_cnt_o, half_bias_o, seg_blank_o and both update pulses are 0, and drive_off_o equals inhibit_i.
- R2: A frame is accepted only when the address is 0x4F. The address is clocked in while enable is low, least significant bit first, so the wire order is 1,1,1,1,0,0,1,0. A frame with any other address changes no output.
- R3: Payload bits are sampled on rising serial clock edges while enable is high. The first payload bit goes to bit 0 of the selected half, and the 32nd goes to its bit 31.
- R4: When payload bit 40 (the direction bit) is 0, disp_o[31:0] is loaded. The control register is also loaded from payload bits 33..38, in the order P0, P1, P2, bias, blank, save.
- R5: When the direction bit is 1, disp_o[63:32] is loaded and the control register is unchanged, whatever payload bits 33..39 carry.
- R6: A frame commits on the falling edge of enable only if exactly 40 payload bits arrived. A frame with 39 or 41 bits changes no output.
- R7: Frames are received correctly whether the serial clock idles low or idles high between transfers.
- R8: Each committed frame raises exactly one of lo_upd_o or hi_upd_o, for exactly one system clock cycle. The pulse appears in the same cycle the store changes.
- R9: Read as a number with P0 as its most significant bit, {P0,P1,P2} = 0..4 gives gp_cnt_o = 0..4. The codes 5..7 give 0. half_bias_o is the bias bit and seg_blank_o is the blank bit.
- R10: While inhibit_i is 1, gp_cnt_o is 0 and drive_off_o is 1. Frames are still received and stored, and the stored control fields reappear once inhibit_i returns to 0.
- R11: When the save bit is set, drive_off_o is 1 and gp_cnt_o still follows the port code.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en_i | input | 1 | Serial enable: low for address, high for payload |
| ser_clk_i | input | 1 | Serial clock |
| ser_dat_i | input | 1 | Serial data |
| inhibit_i | input | 1 | Display inhibit |
| disp_o | output | 64 | Display store |
| gp_cnt_o | output | 3 | Number of pins used as general-purpose outputs |
| half_bias_o | output | 1 | 1 selects half bias, 0 selects third bias |
| seg_blank_o | output | 1 | Segments forced off |
| drive_off_o | output | 1 | Drivers held low (inhibit or save) |
| lo_upd_o | output | 1 | One-cycle pulse on a lower-half commit |
| hi_upd_o | output | 1 | One-cycle pulse on an upper-half commit |

## Verification
The bench sends frames with wrong addresses and frames of 39 and 41 payload bits. A design that counted bits loosely or skipped the address compare would overwrite the store with these. It also sends an upper-half frame whose fixed bits are all ones; a design that loaded the control register on every frame would pick up a bogus port code and set blanking. The bench runs with the serial clock idling both low and high, so a design that treats enable rising while the clock is high as a clock edge loses bit alignment. Frames are also sent under inhibit, so a design that gated reception on inhibit would miss the update.

// File: rtl/disp_cmd_rx.sv
module disp_cmd_rx #(
  parameter logic [7:0] DEV_ADDR    = 8'h4F,
  parameter int         PAY_BITS    = 40,
  parameter int         DISP_BITS   = 64,
  parameter int         CTL_BITS    = 6,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_en_i,
  input  logic                 ser_clk_i,
  input  logic                 ser_dat_i,
  input  logic                 inhibit_i,
  output logic [DISP_BITS-1:0] disp_o,
  output logic [2:0]           gp_cnt_o,
  output logic                 half_bias_o,
  output logic                 seg_blank_o,
  output logic                 drive_off_o,
  output logic                 lo_upd_o,
  output logic                 hi_upd_o
);

  localparam int HALF  = DISP_BITS / 2;
  localparam int CNT_W = $clog2(PAY_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PAY_BITS);
  localparam logic [CNT_W-1:0] CNT_SAT  = '1;

  logic [SYNC_STAGES:0]   en_p, ck_p;
  logic [SYNC_STAGES-1:0] dt_p;
  logic [7:0]             addr_sh;
  logic [PAY_BITS-1:0]    pay_sh;
  logic [CNT_W-1:0]       bit_cnt;
  logic                   hit;
  logic [CTL_BITS-1:0]    ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_p <= '0;
      ck_p <= '0;
      dt_p <= '0;
    end else begin
      en_p <= {en_p[SYNC_STAGES-1:0], ser_en_i};
      ck_p <= {ck_p[SYNC_STAGES-1:0], ser_clk_i};
      dt_p <= {dt_p[SYNC_STAGES-2:0], ser_dat_i};
    end
  end

  wire en_s     = en_p[SYNC_STAGES-1];
  wire en_rise  = en_s & ~en_p[SYNC_STAGES];
  wire en_fall  = ~en_s & en_p[SYNC_STAGES];
  wire clk_rise = ck_p[SYNC_STAGES-1] & ~ck_p[SYNC_STAGES];
  wire dt_s     = dt_p[SYNC_STAGES-1];
  wire commit   = en_fall & hit & (bit_cnt == CNT_FULL);
  wire upper    = pay_sh[PAY_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_sh <= '0;
      pay_sh  <= '0;
      bit_cnt <= '0;
      hit     <= 1'b0;
    end else begin
      if (clk_rise && !en_s) addr_sh <= {dt_s, addr_sh[7:1]};
      if (clk_rise && en_s)  pay_sh  <= {dt_s, pay_sh[PAY_BITS-1:1]};
      if (en_rise) begin
        hit     <= (addr_sh == DEV_ADDR);
        bit_cnt <= '0;
      end else if (clk_rise && en_s && bit_cnt != CNT_SAT) begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_o   <= '0;
      ctl_q    <= '0;
      lo_upd_o <= 1'b0;
      hi_upd_o <= 1'b0;
    end else begin
      lo_upd_o <= commit & ~upper;
      hi_upd_o <= commit & upper;
      if (commit && !upper) begin
        disp_o[HALF-1:0] <= pay_sh[HALF-1:0];
        ctl_q            <= pay_sh[HALF +: CTL_BITS];
      end
      if (commit && upper) disp_o[DISP_BITS-1:HALF] <= pay_sh[HALF-1:0];
    end
  end

  wire [2:0] gp_code = {ctl_q[0], ctl_q[1], ctl_q[2]};

  assign gp_cnt_o    = (inhibit_i || gp_code > 3'd4) ? 3'd0 : gp_code;
  assign half_bias_o = ctl_q[3];
  assign seg_blank_o = ctl_q[4];
  assign drive_off_o = inhibit_i | ctl_q[5];

endmodule

// File: rtl/disp_cmd_rx_chk.sv
module disp_cmd_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ser_en_i,
  input logic [63:0] disp_o,
  input logic        half_bias_o,
  input logic        seg_blank_o,
  input logic        lo_upd_o,
  input logic        hi_upd_o
);

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_upd_o && hi_upd_o)); // R8

  AST_LO_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    lo_upd_o |=> !lo_upd_o); // R8

  AST_HI_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    hi_upd_o |=> !hi_upd_o); // R8

  AST_LO_HALF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_upd_o |-> $stable(disp_o[31:0])); // R4

  AST_HI_HALF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_upd_o |-> $stable(disp_o[63:32])); // R5

  AST_CTL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_upd_o |-> ($stable(half_bias_o) && $stable(seg_blank_o))); // R5

  AST_COMMIT_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_upd_o || hi_upd_o) |-> (!$past(ser_en_i, 3) && $past(ser_en_i, 4))); // R6

endmodule

bind disp_cmd_rx disp_cmd_rx_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ser_en_i   (ser_en_i),
  .disp_o     (disp_o),
  .half_bias_o(half_bias_o),
  .seg_blank_o(seg_blank_o),
  .lo_upd_o   (lo_upd_o),
  .hi_upd_o   (hi_upd_o)
);

// File: tb/test_disp_cmd_rx.sv
module test_disp_cmd_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_en_i = 1'b0, ser_clk_i = 1'b0, ser_dat_i = 1'b0, inhibit_i = 1'b0;
  logic [63:0] disp_o;
  logic [2:0]  gp_cnt_o;
  logic half_bias_o, seg_blank_o, drive_off_o, lo_upd_o, hi_upd_o;

  int compared = 0, mismatched = 0, lo_seen = 0, hi_seen = 0;
  bit idle_hi = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  disp_cmd_rx i_disp_cmd_rx (
    .clk(clk), .rst_n(rst_n), .ser_en_i(ser_en_i), .ser_clk_i(ser_clk_i),
    .ser_dat_i(ser_dat_i), .inhibit_i(inhibit_i), .disp_o(disp_o),
    .gp_cnt_o(gp_cnt_o), .half_bias_o(half_bias_o), .seg_blank_o(seg_blank_o),
    .drive_off_o(drive_off_o), .lo_upd_o(lo_upd_o), .hi_upd_o(hi_upd_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] gp_of(input logic [5:0] c, input logic inh);
    logic [2:0] code;
    code = {c[0], c[1], c[2]};
    if (inh || code > 3'd4) return 3'd0;
    return code;
  endfunction

  // Reference model: queue of raw pin samples, two-cycle synchronizer delay.
  bit [2:0] hq[$];
  bit a_bits[$];
  bit p_bits[$];
  bit m_hit;
  logic [63:0] m_disp;
  logic [5:0]  m_ctl;
  logic m_lo, m_hi;

  always @(posedge clk) begin
    if (!rst_n) begin
      hq.delete();
      a_bits.delete();
      for (int i = 0; i < 8; i++) a_bits.push_back(1'b0);
      p_bits.delete();
      m_hit = 1'b0; m_disp = '0; m_ctl = '0; m_lo = 1'b0; m_hi = 1'b0;
    end else begin
      bit [2:0] cur, prv;
      int av;
      logic [39:0] pv;
      hq.push_back({ser_en_i, ser_clk_i, ser_dat_i});
      if (hq.size() > 4) void'(hq.pop_front());
      cur = (hq.size() >= 3) ? hq[hq.size()-3] : 3'b000;
      prv = (hq.size() >= 4) ? hq[hq.size()-4] : 3'b000;
      m_lo = 1'b0; m_hi = 1'b0;
      if (cur[1] && !prv[1]) begin
        if (!cur[2]) begin a_bits.push_back(cur[0]); void'(a_bits.pop_front()); end
        else p_bits.push_back(cur[0]);
      end
      if (cur[2] && !prv[2]) begin
        av = 0;
        for (int i = 0; i < 8; i++) av += int'(a_bits[i]) << i;
        m_hit = (av == 'h4F);
        p_bits.delete();
      end
      if (!cur[2] && prv[2] && m_hit && p_bits.size() == 40) begin
        for (int i = 0; i < 40; i++) pv[i] = p_bits[i];
        if (!pv[39]) begin m_disp[31:0] = pv[31:0]; m_ctl = pv[37:32]; m_lo = 1'b1; end
        else begin m_disp[63:32] = pv[31:0]; m_hi = 1'b1; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(disp_o === m_disp, "R4 disp", disp_o, m_disp);
      chk({half_bias_o, seg_blank_o, gp_cnt_o} === {m_ctl[3], m_ctl[4], gp_of(m_ctl, inhibit_i)},
          "R9 ctl", {half_bias_o, seg_blank_o, gp_cnt_o}, {m_ctl[3], m_ctl[4], gp_of(m_ctl, inhibit_i)});
      chk(drive_off_o === (inhibit_i | m_ctl[5]), "R11 drive_off", drive_off_o, inhibit_i | m_ctl[5]);
      chk({lo_upd_o, hi_upd_o} === {m_lo, m_hi}, "R8 pulse", {lo_upd_o, hi_upd_o}, {m_lo, m_hi});
      if (lo_upd_o) lo_seen++;
      if (hi_upd_o) hi_seen++;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ser_bit(input logic b);
    if (idle_hi) begin
      ser_clk_i = 1'b0; ser_dat_i = b; wt(4);
      ser_clk_i = 1'b1; wt(4);
    end else begin
      ser_dat_i = b; wt(4);
      ser_clk_i = 1'b1; wt(4);
      ser_clk_i = 1'b0; wt(2);
    end
  endtask

  task automatic send(input logic [7:0] addr, input logic [39:0] pay, input int nbits);
    ser_en_i = 1'b0;
    ser_clk_i = idle_hi;
    wt(4);
    for (int i = 0; i < 8; i++) ser_bit(addr[i]);
    wt(4);
    ser_en_i = 1'b1;
    wt(4);
    for (int i = 0; i < nbits; i++) ser_bit(i < 40 ? pay[i] : 1'b0);
    wt(4);
    ser_en_i = 1'b0;
    wt(8);
  endtask

  function automatic logic [39:0] lo_frame(input logic [31:0] d, input logic [5:0] c);
    return {1'b0, 1'b0, c, d};
  endfunction

  function automatic logic [39:0] hi_frame(input logic [31:0] d, input logic [6:0] fixed);
    return {1'b1, fixed, d};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    wt(3);
    chk(disp_o === 64'h0, "R1 disp reset", disp_o, 64'h0);
    chk({gp_cnt_o, half_bias_o, seg_blank_o, drive_off_o, lo_upd_o, hi_upd_o} === 8'h00,
        "R1 ctl reset", {gp_cnt_o, half_bias_o, seg_blank_o, drive_off_o, lo_upd_o, hi_upd_o}, 8'h00);
    rst_n = 1'b1;
    wt(4);

    // lower half, clock idling low; port code 4, half bias
    send(8'h4F, lo_frame(32'hA5C3_0F81, 6'b001001), 40);
    chk(disp_o[31:0] === 32'hA5C3_0F81, "R3 bit order", disp_o[31:0], 32'hA5C3_0F81);
    chk(gp_cnt_o === 3'd4, "R9 code4", gp_cnt_o, 3'd4);
    chk(half_bias_o === 1'b1, "R4 bias", half_bias_o, 1'b1);

    // upper half with nonzero fixed bits
    send(8'h4F, hi_frame(32'h1234_5678, 7'h7F), 40);
    chk(disp_o === 64'h1234_5678_A5C3_0F81, "R5 upper", disp_o, 64'h1234_5678_A5C3_0F81);
    chk({gp_cnt_o, half_bias_o, seg_blank_o} === 5'b10010, "R5 ctl kept",
        {gp_cnt_o, half_bias_o, seg_blank_o}, 5'b10010);

    // wrong addresses
    send(8'h4E, lo_frame(32'hFFFF_FFFF, 6'b111111), 40);
    send(8'hF2, hi_frame(32'hFFFF_FFFF, 7'h00), 40);
    chk(disp_o === 64'h1234_5678_A5C3_0F81, "R2 addr", disp_o, 64'h1234_5678_A5C3_0F81);

    // wrong lengths
    send(8'h4F, lo_frame(32'h0, 6'b000000), 39);
    send(8'h4F, hi_frame(32'h0, 7'h00), 41);
    chk(disp_o === 64'h1234_5678_A5C3_0F81, "R6 length", disp_o, 64'h1234_5678_A5C3_0F81);

    // clock idling high; port code 3, blank
    idle_hi = 1'b1;
    send(8'h4F, lo_frame(32'hDEAD_BEEF, 6'b010110), 40);
    chk(disp_o === 64'h1234_5678_DEAD_BEEF, "R7 idle high", disp_o, 64'h1234_5678_DEAD_BEEF);
    chk({gp_cnt_o, seg_blank_o, half_bias_o} === 5'b01110, "R7 ctl",
        {gp_cnt_o, seg_blank_o, half_bias_o}, 5'b01110);
    idle_hi = 1'b0;
    ser_clk_i = 1'b0;
    wt(6);

    // inhibit: frame still stored
    inhibit_i = 1'b1;
    send(8'h4F, hi_frame(32'hCAFE_F00D, 7'h00), 40);
    chk(disp_o === 64'hCAFE_F00D_DEAD_BEEF, "R10 stored", disp_o, 64'hCAFE_F00D_DEAD_BEEF);
    chk({gp_cnt_o, drive_off_o} === 4'b0001, "R10 forced", {gp_cnt_o, drive_off_o}, 4'b0001);
    inhibit_i = 1'b0;
    wt(1);
    chk({gp_cnt_o, drive_off_o} === 4'b0110, "R10 release", {gp_cnt_o, drive_off_o}, 4'b0110);

    // invalid port code 5 with save
    send(8'h4F, lo_frame(32'h0000_0001, 6'b100101), 40);
    chk(gp_cnt_o === 3'd0, "R9 code5", gp_cnt_o, 3'd0);
    chk(drive_off_o === 1'b1, "R11 save", drive_off_o, 1'b1);

    // save with valid code 2 keeps ports
    send(8'h4F, lo_frame(32'h0000_0002, 6'b100010), 40);
    chk({gp_cnt_o, drive_off_o} === 4'b0101, "R11 ports kept", {gp_cnt_o, drive_off_o}, 4'b0101);

    wt(4);
    chk(lo_seen === 4, "R8 lo count", 64'(lo_seen), 64'd4);
    chk(hi_seen === 2, "R8 hi count", 64'(hi_seen), 64'd2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule